// File: doc/BRIEF.md
# Sector Command Sequencer

This block runs one sector command against a storage controller that sits behind an 8-bit register window. It takes the place of a driver routine. A start pulse captures a command byte, a 24-bit sector number and a flag that says whether a response buffer is present. The sequencer puts the controller into command mode and loads the three parameter bytes. It then polls the status register, with a bounded counter on every poll pass, before it writes the command byte.

What follows the command byte depends on bit 5 of that byte. When bit 5 is set, the sequencer streams a 256-byte block from an attached buffer RAM to the controller. It then waits for the controller to finish, allowing several poll passes. When bit 5 is clear, it waits with a doubled poll window. If the controller offers response data and a buffer is present, the sequencer copies 256 bytes into the buffer RAM.

Every transaction with the device present ends by taking the controller out of command mode. After that, the block gives a one-cycle done pulse together with a result byte and a fault flag.

Top module: `sector_cmd_seq`

## Requirements
- R1: With the device present, a start makes exactly these first four bus writes, in this order: 0x43 to offset 0x0, sector[23:16] to 0x9, sector[15:8] to 0xA, sector[7:0] to 0xB.
- R2: Before the command byte is written to offset 0x8, the sequencer reads status at 0x8 once per cycle. It stops when bit 0 (busy) is clear or bit 1 (ready) is set, so a controller that shows busy for b reads, with b < POLL_LEN, costs b+1 status reads.
- R3: A status read with bit 7 set ends the transaction. The result is that status byte and fault is 1. During the pre-command wait this means the command byte is never written.
- R4: A poll pass that makes POLL_LEN status reads without reaching an outcome is a timeout. A timeout in the pre-command wait ends the transaction with result 0x81 and fault 1.
- R5: When command bit 5 is set, the sequencer runs one poll pass after the command byte. It then writes buffer bytes 0 to 255 in order: even indices go to offset 0xA and odd indices go to offset 0xB.
- R6: After a block write, up to 5 poll passes wait for busy to clear. A pass that ends on ready counts as still busy. If busy never clears, the result is 0x81 with fault 1, after exactly 5*POLL_LEN reads when the controller stays busy.
- R7: When command bit 5 is clear, the wait after the command byte may use two poll passes (2*POLL_LEN reads) before a timeout (0x81, fault 1). If that wait ends with busy clear, the transaction succeeds with no data reads.
- R8: If that wait ends on ready and the buffer flag is set, the sequencer reads 256 bytes, alternating between offsets 0xA and 0xB, and stores byte i at buffer address i. Without the buffer flag, it makes no data read and succeeds.
- R9: When the device is present, the last bus cycle of every transaction writes 0x00 to offset 0x0, whether the transaction succeeds or fails. A successful transaction returns result 0 and fault 0.
- R10: With the device absent, a start produces done on the next cycle with result 0xF6 and fault 1, and no bus cycle is issued.
- R11: Done is high for exactly one cycle per transaction. While the block is idle, and after reset, the block issues no bus read or write and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a transaction when the block is idle |
| cmd_code | input | 8 | Command byte; bit 5 selects block write |
| sector | input | 24 | Sector number / parameter bytes |
| buf_valid | input | 1 | A response buffer is present |
| dev_present | input | 1 | The controller is present |
| done | output | 1 | One-cycle end-of-transaction pulse |
| result | output | 8 | Result code, valid with done |
| fault | output | 1 | Error flag, valid with done |
| bus_addr | output | 4 | Register offset in the controller window |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe; data sampled the same cycle |
| bus_wdata | output | 8 | Register write data |
| bus_rdata | input | 8 | Register read data |
| buf_addr | output | 8 | Buffer RAM address |
| buf_we | output | 1 | Buffer RAM write enable |
| buf_wdata | output | 8 | Buffer RAM write data |
| buf_rdata | input | 8 | Buffer RAM read data, one cycle after the address |

## Verification
A pass counter that goes wrong shows up as a number of status reads per phase that differs from busy+1 or from a whole multiple of POLL_LEN. It is visible as soon as that phase ends. A lost phase transition shows up as a wrong next bus write: a missing command byte, data going to the wrong port, or a missing final write to offset 0x0. It is seen within one transaction. A byte counter that is off by one puts a block byte on the wrong port or at the wrong buffer address, and this shows when the bench compares the block at done.

// File: rtl/seqr_pkg.sv
// Package: shared codes, register offsets and FSM states of the sector
// command sequencer. Assumes a 16-byte controller register window.
package seqr_pkg;

    localparam logic [3:0] REG_LATCH = 4'h0;
    localparam logic [3:0] REG_CMD   = 4'h8;
    localparam logic [3:0] REG_PAR1  = 4'h9;
    localparam logic [3:0] REG_DATA_A = 4'hA;
    localparam logic [3:0] REG_DATA_B = 4'hB;

    localparam logic [7:0] LATCH_ON  = 8'h43;
    localparam logic [7:0] LATCH_OFF = 8'h00;
    localparam logic [7:0] CODE_TIMEOUT = 8'h81;

    localparam int STAT_BUSY  = 0;
    localparam int STAT_READY = 1;
    localparam int STAT_FAIL  = 7;
    localparam int CMD_TX_BIT = 5;

    typedef enum logic [1:0] {
        PR_DONE,
        PR_READY,
        PR_FAIL,
        PR_TIMEOUT
    } poll_res_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LATCH,
        S_PAR_HI,
        S_PAR_MID,
        S_PAR_LO,
        S_PRE_WAIT,
        S_CMD,
        S_TX_WAIT,
        S_TX,
        S_CMPL_WAIT,
        S_LONG_WAIT,
        S_RX,
        S_EXIT
    } seq_state_e;

endpackage

// File: rtl/seqr_poll.sv
// Poll pass engine: once launched, reads status every cycle until busy clears,
// ready shows with busy, fail is flagged, or POLL_LEN reads pass without an
// outcome. Assumes read data is valid in the same cycle as the read strobe.
module seqr_poll
    import seqr_pkg::*;
#(
    parameter int POLL_LEN = 65536
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] rdata,
    output logic       rd_req,
    output logic       res_v,
    output poll_res_e  res,
    output logic [7:0] res_stat
);

    localparam int CW = $clog2(POLL_LEN + 1);

    logic          active;
    logic [CW-1:0] cnt;

    assign rd_req = active;

    // Runs the pass: counts reads and registers the outcome of the pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cnt      <= '0;
            res_v    <= 1'b0;
            res      <= PR_DONE;
            res_stat <= 8'h00;
        end else begin
            res_v <= 1'b0;
            if (go && !active) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (active) begin
                if (rdata[STAT_FAIL]) begin
                    active   <= 1'b0;
                    res_v    <= 1'b1;
                    res      <= PR_FAIL;
                    res_stat <= rdata;
                end else if (!rdata[STAT_BUSY]) begin
                    active   <= 1'b0;
                    res_v    <= 1'b1;
                    res      <= PR_DONE;
                    res_stat <= 8'h00;
                end else if (rdata[STAT_READY]) begin
                    active   <= 1'b0;
                    res_v    <= 1'b1;
                    res      <= PR_READY;
                    res_stat <= rdata;
                end else if (cnt == CW'(POLL_LEN - 1)) begin
                    active   <= 1'b0;
                    res_v    <= 1'b1;
                    res      <= PR_TIMEOUT;
                    res_stat <= CODE_TIMEOUT;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4: a pass never makes more than POLL_LEN reads.
    a_r4_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (int'(cnt) < POLL_LEN));

    // R3: a fail flag on a read ends the pass with a fail outcome next cycle.
    a_r3_fail_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rdata[STAT_FAIL]) |=> (res_v && res == PR_FAIL && !active));

endmodule

// File: rtl/seqr_xfer.sv
// Block mover: copies BLK_LEN bytes between the buffer RAM and the two
// alternating data ports. A transmit byte takes two cycles (a RAM fetch, then
// a port write); a receive byte takes one cycle. Assumes a RAM read latency of
// one cycle and BLK_LEN a power of two.
module seqr_xfer #(
    parameter int BLK_LEN = 256,
    localparam int AW = $clog2(BLK_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          tx,
    input  logic [7:0]    ram_rdata,
    input  logic [7:0]    port_rdata,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic [7:0]    ram_wdata,
    output logic          port_wr,
    output logic          port_rd,
    output logic          port_odd,
    output logic [7:0]    port_wdata,
    output logic          fin
);

    logic          active;
    logic          dir_tx;
    logic          phase;
    logic [AW-1:0] idx;
    logic          step;
    logic          last;

    assign step = active && (!dir_tx || phase);
    assign last = (idx == AW'(BLK_LEN - 1));

    // Drives the RAM and port strobes for the current byte.
    always_comb begin
        ram_addr   = idx;
        ram_we     = active && !dir_tx;
        ram_wdata  = port_rdata;
        port_rd    = active && !dir_tx;
        port_wr    = active && dir_tx && phase;
        port_odd   = idx[0];
        port_wdata = ram_rdata;
    end

    // Advances the byte index and the fetch/write phase; flags the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            dir_tx <= 1'b0;
            phase  <= 1'b0;
            idx    <= '0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go && !active) begin
                active <= 1'b1;
                dir_tx <= tx;
                phase  <= 1'b0;
                idx    <= '0;
            end else if (active) begin
                if (dir_tx) begin
                    phase <= !phase;
                end
                if (step) begin
                    idx <= idx + 1'b1;
                    if (last) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                    end
                end
            end
        end
    end

    // R5: reads and writes on the data ports never share a cycle.
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_wr && port_rd));

endmodule

// File: rtl/sector_cmd_seq.sv
// Sector command sequencer top: runs a transaction through command mode
// entry, parameter load, pre-command poll, command write, optional block
// write or read, and command mode exit. Assumes a combinational register read
// path and a buffer RAM with one cycle of read latency.
module sector_cmd_seq
    import seqr_pkg::*;
#(
    parameter int         POLL_LEN     = 65536,
    parameter int         RETRIES      = 5,
    parameter int         BLK_LEN      = 256,
    parameter logic [7:0] MISSING_CODE = 8'hF6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [7:0]                 cmd_code,
    input  logic [23:0]                sector,
    input  logic                       buf_valid,
    input  logic                       dev_present,
    output logic                       done,
    output logic [7:0]                 result,
    output logic                       fault,
    output logic [3:0]                 bus_addr,
    output logic                       bus_wr,
    output logic                       bus_rd,
    output logic [7:0]                 bus_wdata,
    input  logic [7:0]                 bus_rdata,
    output logic [$clog2(BLK_LEN)-1:0] buf_addr,
    output logic                       buf_we,
    output logic [7:0]                 buf_wdata,
    input  logic [7:0]                 buf_rdata
);

    localparam int PW = $clog2(RETRIES + 1);
    localparam int AW = $clog2(BLK_LEN);

    seq_state_e    state;
    logic [7:0]    cmd_q;
    logic [23:0]   sec_q;
    logic          bufv_q;
    logic          absent_q;
    logic          launched;
    logic [PW-1:0] pass_cnt;
    logic [7:0]    ret_code;
    logic          ret_err;

    logic          in_poll;
    logic          in_xfer;
    logic          poll_go;
    logic          poll_rd;
    logic          poll_v;
    poll_res_e     poll_r;
    logic [7:0]    poll_stat;

    logic          x_go;
    logic [AW-1:0] x_addr;
    logic          x_we;
    logic [7:0]    x_wdata;
    logic          x_wr;
    logic          x_rd;
    logic          x_odd;
    logic [7:0]    x_pdata;
    logic          x_fin;

    assign in_poll = (state == S_PRE_WAIT) || (state == S_TX_WAIT) ||
                     (state == S_CMPL_WAIT) || (state == S_LONG_WAIT);
    assign in_xfer = (state == S_TX) || (state == S_RX);
    assign poll_go = in_poll && !launched;
    assign x_go    = in_xfer && !launched;

    seqr_poll #(.POLL_LEN(POLL_LEN)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (poll_go),
        .rdata    (bus_rdata),
        .rd_req   (poll_rd),
        .res_v    (poll_v),
        .res      (poll_r),
        .res_stat (poll_stat)
    );

    seqr_xfer #(.BLK_LEN(BLK_LEN)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (x_go),
        .tx         (state == S_TX),
        .ram_rdata  (buf_rdata),
        .port_rdata (bus_rdata),
        .ram_addr   (x_addr),
        .ram_we     (x_we),
        .ram_wdata  (x_wdata),
        .port_wr    (x_wr),
        .port_rd    (x_rd),
        .port_odd   (x_odd),
        .port_wdata (x_pdata),
        .fin        (x_fin)
    );

    assign buf_addr  = x_addr;
    assign buf_we    = x_we;
    assign buf_wdata = x_wdata;

    // Selects the single bus cycle issued by the FSM or by a sub-engine.
    always_comb begin
        bus_addr  = REG_LATCH;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_wdata = 8'h00;
        case (state)
            S_LATCH:   begin bus_wr = 1'b1; bus_addr = REG_LATCH;  bus_wdata = LATCH_ON;      end
            S_PAR_HI:  begin bus_wr = 1'b1; bus_addr = REG_PAR1;   bus_wdata = sec_q[23:16];  end
            S_PAR_MID: begin bus_wr = 1'b1; bus_addr = REG_DATA_A; bus_wdata = sec_q[15:8];   end
            S_PAR_LO:  begin bus_wr = 1'b1; bus_addr = REG_DATA_B; bus_wdata = sec_q[7:0];    end
            S_CMD:     begin bus_wr = 1'b1; bus_addr = REG_CMD;    bus_wdata = cmd_q;         end
            S_EXIT:    begin bus_wr = 1'b1; bus_addr = REG_LATCH;  bus_wdata = LATCH_OFF;     end
            S_TX, S_RX: begin
                bus_wr    = x_wr;
                bus_rd    = x_rd;
                bus_addr  = x_odd ? REG_DATA_B : REG_DATA_A;
                bus_wdata = x_pdata;
            end
            default: begin
                bus_rd   = poll_rd;
                bus_addr = REG_CMD;
            end
        endcase
    end

    // Sequences the transaction and registers the done/result/fault outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cmd_q    <= 8'h00;
            sec_q    <= 24'h0;
            bufv_q   <= 1'b0;
            absent_q <= 1'b0;
            launched <= 1'b0;
            pass_cnt <= '0;
            ret_code <= 8'h00;
            ret_err  <= 1'b0;
            done     <= 1'b0;
            result   <= 8'h00;
            fault    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (poll_go || x_go) begin
                launched <= 1'b1;
            end else if (poll_v || x_fin) begin
                launched <= 1'b0;
            end
            case (state)
                S_IDLE: begin
                    if (start) begin
                        cmd_q  <= cmd_code;
                        sec_q  <= sector;
                        bufv_q <= buf_valid;
                        ret_code <= 8'h00;
                        ret_err  <= 1'b0;
                        if (!dev_present) begin
                            absent_q <= 1'b1;
                            done     <= 1'b1;
                            result   <= MISSING_CODE;
                            fault    <= 1'b1;
                        end else begin
                            absent_q <= 1'b0;
                            state    <= S_LATCH;
                        end
                    end
                end
                S_LATCH:   state <= S_PAR_HI;
                S_PAR_HI:  state <= S_PAR_MID;
                S_PAR_MID: state <= S_PAR_LO;
                S_PAR_LO:  state <= S_PRE_WAIT;
                S_PRE_WAIT: begin
                    if (poll_v) begin
                        if (poll_r == PR_FAIL || poll_r == PR_TIMEOUT) begin
                            ret_code <= poll_stat;
                            ret_err  <= 1'b1;
                            state    <= S_EXIT;
                        end else begin
                            state <= S_CMD;
                        end
                    end
                end
                S_CMD: begin
                    pass_cnt <= '0;
                    state    <= cmd_q[CMD_TX_BIT] ? S_TX_WAIT : S_LONG_WAIT;
                end
                S_TX_WAIT: begin
                    if (poll_v) begin
                        if (poll_r == PR_FAIL || poll_r == PR_TIMEOUT) begin
                            ret_code <= poll_stat;
                            ret_err  <= 1'b1;
                            state    <= S_EXIT;
                        end else begin
                            state <= S_TX;
                        end
                    end
                end
                S_TX: begin
                    if (x_fin) begin
                        pass_cnt <= '0;
                        state    <= S_CMPL_WAIT;
                    end
                end
                S_CMPL_WAIT: begin
                    if (poll_v) begin
                        if (poll_r == PR_DONE) begin
                            state <= S_EXIT;
                        end else if (poll_r == PR_FAIL) begin
                            ret_code <= poll_stat;
                            ret_err  <= 1'b1;
                            state    <= S_EXIT;
                        end else if (pass_cnt == PW'(RETRIES - 1)) begin
                            ret_code <= CODE_TIMEOUT;
                            ret_err  <= 1'b1;
                            state    <= S_EXIT;
                        end else begin
                            pass_cnt <= pass_cnt + 1'b1;
                        end
                    end
                end
                S_LONG_WAIT: begin
                    if (poll_v) begin
                        case (poll_r)
                            PR_DONE: state <= S_EXIT;
                            PR_READY: state <= bufv_q ? S_RX : S_EXIT;
                            PR_FAIL: begin
                                ret_code <= poll_stat;
                                ret_err  <= 1'b1;
                                state    <= S_EXIT;
                            end
                            default: begin
                                if (pass_cnt == '0) begin
                                    pass_cnt <= PW'(1);
                                end else begin
                                    ret_code <= CODE_TIMEOUT;
                                    ret_err  <= 1'b1;
                                    state    <= S_EXIT;
                                end
                            end
                        endcase
                    end
                end
                S_RX: begin
                    if (x_fin) begin
                        state <= S_EXIT;
                    end
                end
                S_EXIT: begin
                    done   <= 1'b1;
                    result <= ret_code;
                    fault  <= ret_err;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11: no bus activity while idle.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (!bus_wr && !bus_rd));

    // R9: every present-device transaction ends by leaving command mode.
    a_r9_exit_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !absent_q) |-> $past(bus_wr && bus_addr == REG_LATCH && bus_wdata == LATCH_OFF));

    // R10: an absent device ends the transaction at once without bus cycles.
    a_r10_absent_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && !dev_present) |=> (done && fault && !bus_wr && !bus_rd));

    // R8: the buffer is only written when the caller supplied one.
    a_r8_store_needs_buf: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> bufv_q);

    // R2: the command byte follows a poll pass that did not fail.
    a_r2_cmd_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_CMD) |-> ($past(poll_v) && $past(poll_r) != PR_FAIL
                                             && $past(poll_r) != PR_TIMEOUT));

endmodule

// File: tb/sector_cmd_seq_tb.sv
// Bench: a scripted controller model (busy count and final status per phase)
// and a buffer RAM, with sweeps over busy lengths and command kinds.
module sector_cmd_seq_tb;

    localparam int PL = 8;
    localparam int NLOG = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic [23:0] sector = 24'h0;
    logic        buf_valid = 1'b0;
    logic        dev_present = 1'b1;
    logic        done;
    logic [7:0]  result;
    logic        fault;
    logic [3:0]  bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [7:0]  buf_addr;
    logic        buf_we;
    logic [7:0]  buf_wdata;
    logic [7:0]  buf_rdata;

    always #5 clk = ~clk;

    sector_cmd_seq #(.POLL_LEN(PL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code),
        .sector(sector), .buf_valid(buf_valid), .dev_present(dev_present),
        .done(done), .result(result), .fault(fault), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .buf_addr(buf_addr), .buf_we(buf_we),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    // Controller model configuration (driven by the stimulus only).
    int          cfg_busy [3];
    logic [7:0]  cfg_fin  [3];
    logic        model_load = 1'b0;

    // Controller model state (driven by the model process only).
    int          busy_left [3];
    int          ph;
    int          rd_stat [3];
    int          n_dread;
    int          n_dwr;
    int          n_wr;
    int          port_err;
    logic [3:0]  wa [NLOG];
    logic [7:0]  wd [NLOG];
    logic [7:0]  rxmem [256];

    function automatic logic [7:0] dpat(int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] src(int i);
        return 8'(((i * 13) + 1) & 255) ^ 8'h5A;
    endfunction

    // Combinational register read path of the model.
    always_comb begin
        if (bus_addr == 4'h8)
            bus_rdata = (busy_left[ph] > 0) ? 8'h01 : cfg_fin[ph];
        else if (bus_addr == 4'hA || bus_addr == 4'hB)
            bus_rdata = dpat(n_dread);
        else
            bus_rdata = 8'h00;
    end

    // Model state update and bus logging.
    always @(posedge clk) begin
        if (model_load) begin
            ph <= 0;
            n_dread <= 0;
            n_dwr <= 0;
            n_wr <= 0;
            port_err <= 0;
            for (int k = 0; k < 3; k++) begin
                busy_left[k] <= cfg_busy[k];
                rd_stat[k] <= 0;
            end
            for (int k = 0; k < 256; k++) rxmem[k] <= 8'h00;
        end else begin
            if (bus_wr) begin
                if (n_wr < NLOG) begin
                    wa[n_wr] <= bus_addr;
                    wd[n_wr] <= bus_wdata;
                end
                n_wr <= n_wr + 1;
                if (bus_addr == 4'h8) ph <= 1;
                if ((bus_addr == 4'hA || bus_addr == 4'hB) && ph == 1) begin
                    if (n_dwr == 255) ph <= 2;
                    n_dwr <= n_dwr + 1;
                end
            end
            if (bus_rd && bus_addr == 4'h8) begin
                rd_stat[ph] <= rd_stat[ph] + 1;
                if (busy_left[ph] > 0) busy_left[ph] <= busy_left[ph] - 1;
            end
            if (bus_rd && (bus_addr == 4'hA || bus_addr == 4'hB)) begin
                if ((bus_addr == 4'hA) != (n_dread % 2 == 0)) port_err <= port_err + 1;
                n_dread <= n_dread + 1;
            end
        end
        buf_rdata <= src(int'(buf_addr));
        if (buf_we) rxmem[buf_addr] <= buf_wdata;
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic setup(input int b0, input logic [7:0] f0, input int b1,
                         input logic [7:0] f1, input int b2, input logic [7:0] f2);
        cfg_busy[0] = b0; cfg_fin[0] = f0;
        cfg_busy[1] = b1; cfg_fin[1] = f1;
        cfg_busy[2] = b2; cfg_fin[2] = f2;
        @(negedge clk); model_load = 1'b1;
        @(negedge clk); model_load = 1'b0;
    endtask

    logic [7:0] got_res;
    logic       got_fault;

    task automatic run(input logic [7:0] c, input logic [23:0] s, input logic bv, input logic dp);
        int guard;
        cmd_code = c; sector = s; buf_valid = bv; dev_present = dp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, "R11 done reached", int'(done), 1);
        got_res = result;
        got_fault = fault;
        @(negedge clk);
        check(done == 1'b0, "R11 done one cycle", int'(done), 0);
    endtask

    task automatic check_exit(input string req);
        check(n_wr > 0 && wa[n_wr-1] == 4'h0 && wd[n_wr-1] == 8'h00, "R9 last write latch off",
              int'(wd[n_wr-1]), 0);
    endtask

    task automatic check_head(input logic [23:0] s);
        check(wa[0] == 4'h0 && wd[0] == 8'h43, "R1 latch on", int'(wd[0]), 'h43);
        check(wa[1] == 4'h9 && wd[1] == s[23:16], "R1 param hi", int'(wd[1]), int'(s[23:16]));
        check(wa[2] == 4'hA && wd[2] == s[15:8], "R1 param mid", int'(wd[2]), int'(s[15:8]));
        check(wa[3] == 4'hB && wd[3] == s[7:0], "R1 param lo", int'(wd[3]), int'(s[7:0]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int bad;
        setup(0, 8'h00, 0, 8'h00, 0, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        check(!done && !bus_wr && !bus_rd, "R11 reset quiet", int'({done, bus_wr, bus_rd}), 0);

        // R10: device absent.
        setup(0, 8'h00, 0, 8'h00, 0, 8'h00);
        run(8'h80, 24'h000001, 1'b1, 1'b0);
        check(got_res == 8'hF6 && got_fault, "R10 missing code", int'(got_res), 'hF6);
        check(n_wr == 0 && rd_stat[0] == 0, "R10 no bus cycles", n_wr, 0);

        // R2/R7: sweep pre-command busy lengths, read command that completes at once.
        for (int b = 0; b < PL; b++) begin
            setup(b, 8'h00, 0, 8'h00, 0, 8'h00);
            run(8'h80, 24'h0A0B0C + 24'(b), 1'b1, 1'b1);
            check(rd_stat[0] == b + 1, "R2 pre poll reads", rd_stat[0], b + 1);
            check(wa[4] == 4'h8 && wd[4] == 8'h80, "R2 command byte", int'(wd[4]), 'h80);
            check(got_res == 8'h00 && !got_fault && n_dread == 0, "R7 done no data",
                  int'(got_res), 0);
            check_head(24'h0A0B0C + 24'(b));
            check_exit("R9");
        end

        // R4: pre-command timeout.
        setup(1000, 8'h00, 0, 8'h00, 0, 8'h00);
        run(8'h80, 24'h123456, 1'b1, 1'b1);
        check(got_res == 8'h81 && got_fault, "R4 timeout code", int'(got_res), 'h81);
        check(rd_stat[0] == PL, "R4 reads per pass", rd_stat[0], PL);
        check(n_wr == 5, "R4 no command written", n_wr, 5);
        check_exit("R9");

        // R3: fail flag during pre-command wait.
        setup(2, 8'h85, 0, 8'h00, 0, 8'h00);
        run(8'hA0, 24'h000102, 1'b1, 1'b1);
        check(got_res == 8'h85 && got_fault, "R3 fail status", int'(got_res), 'h85);
        check(rd_stat[0] == 3 && n_wr == 5, "R3 no command", n_wr, 5);
        check_exit("R9");

        // R8: ready with buffer, block read.
        setup(3, 8'h00, 2, 8'h03, 0, 8'h00);
        run(8'h80, 24'h123456, 1'b1, 1'b1);
        check_head(24'h123456);
        check(got_res == 8'h00 && !got_fault, "R9 success", int'(got_res), 0);
        check(n_dread == 256 && port_err == 0, "R8 read count alternating", n_dread, 256);
        bad = 0;
        for (int k = 0; k < 256; k++) if (rxmem[k] != dpat(k)) bad++;
        check(bad == 0, "R8 buffer contents", bad, 0);
        check_exit("R9");

        // R8: ready after a long wait but no buffer flagged.
        setup(0, 8'h00, PL + 2, 8'h03, 0, 8'h00);
        run(8'hC0, 24'h00FFFF, 1'b0, 1'b1);
        check(got_res == 8'h00 && !got_fault && n_dread == 0, "R8 no buffer skip", n_dread, 0);
        check(rd_stat[1] == PL + 3, "R7 second pass used", rd_stat[1], PL + 3);
        bad = 0;
        for (int k = 0; k < 256; k++) if (rxmem[k] != 8'h00) bad++;
        check(bad == 0, "R8 buffer untouched", bad, 0);

        // R7: long wait timeout.
        setup(0, 8'h00, 1000, 8'h00, 0, 8'h00);
        run(8'h80, 24'h000010, 1'b1, 1'b1);
        check(got_res == 8'h81 && got_fault, "R7 long timeout", int'(got_res), 'h81);
        check(rd_stat[1] == 2 * PL, "R7 doubled reads", rd_stat[1], 2 * PL);
        check_exit("R9");

        // R3: fail flag during long wait.
        setup(0, 8'h00, 1, 8'h84, 0, 8'h00);
        run(8'hC0, 24'h000011, 1'b1, 1'b1);
        check(got_res == 8'h84 && got_fault, "R3 long wait fail", int'(got_res), 'h84);

        // R5/R6: block writes with completion needing several passes.
        for (int p = 0; p < 5; p++) begin
            setup(0, 8'h00, 1, 8'h03, p * PL + 2, 8'h00);
            run((p % 2 == 0) ? 8'hA0 : 8'hE0, 24'h345678, 1'b1, 1'b1);
            check(got_res == 8'h00 && !got_fault, "R6 completion ok", int'(got_res), 0);
            check(rd_stat[2] == p * PL + 3, "R6 completion reads", rd_stat[2], p * PL + 3);
            check(n_wr == 262, "R5 write count", n_wr, 262);
            bad = 0;
            for (int k = 0; k < 256; k++) begin
                if (wa[5 + k] != ((k % 2 == 0) ? 4'hA : 4'hB)) bad++;
                if (wd[5 + k] != src(k)) bad++;
            end
            check(bad == 0, "R5 block data and ports", bad, 0);
            check_exit("R9");
        end

        // R6: completion never clears.
        setup(0, 8'h00, 0, 8'h03, 1000, 8'h00);
        run(8'hA0, 24'h000020, 1'b1, 1'b1);
        check(got_res == 8'h81 && got_fault, "R6 completion timeout", int'(got_res), 'h81);
        check(rd_stat[2] == 5 * PL, "R6 five passes", rd_stat[2], 5 * PL);
        check_exit("R9");

        // R6: ready during completion counts as busy, 5 one-read passes.
        setup(0, 8'h00, 0, 8'h03, 0, 8'h03);
        run(8'hA0, 24'h000021, 1'b1, 1'b1);
        check(got_res == 8'h81 && got_fault && rd_stat[2] == 5, "R6 ready is busy",
              rd_stat[2], 5);

        // R3: fail during completion.
        setup(0, 8'h00, 0, 8'h03, 0, 8'h84);
        run(8'hA0, 24'h000022, 1'b1, 1'b1);
        check(got_res == 8'h84 && got_fault, "R3 completion fail", int'(got_res), 'h84);

        // R11: quiet after transactions.
        repeat (4) @(negedge clk);
        check(!bus_wr && !bus_rd && !done, "R11 idle quiet", int'({bus_wr, bus_rd}), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule